// File: doc/BRIEF.md
# Bit Clock Recovery with NRZI Decode

This block sits between a demodulator's per-sample hard-decision output and a link-layer deframer. It accepts one sliced sample bit per valid cycle, at eight samples per bit period. It regenerates the bit timing from those samples with a small phase accumulator. Each transition in the sample stream pulls the accumulator slightly toward the middle of its range.

The accumulator wraps at the end of each bit period. At that point the block settles the bit value with a two-of-three vote over the newest samples. It then converts the line coding: a repeated level decodes as a one and a change of level decodes as a zero. It presents the decoded bit with a single-cycle strobe.

The phase register is signed and eight bits wide. The accumulator advances by 8 on every sample and wraps at 64. Its midpoint is 32 and each nudge is 1. All of these values are parameters.

Top module: `bit_sync_nrzi`

## Requirements
- R1: On a cycle with `smp_valid` high, `smp_bit` enters bit 0 of an 8-bit sample history and the older bits move up one place. On a cycle with `smp_valid` low, the history, the phase and the outputs keep their values, and no strobe is issued.
- R2: A transition is present when bits 0 and 1 of the updated history differ. On a transition, the phase first moves by 1: up if it is below 32, down otherwise.
- R3: Every accepted sample adds 8 to the phase, whether or not a transition occurred.
- R4: When the phase reaches 64 or more, 64 is subtracted and a bit decision is taken. The phase always stays between 0 and 63.
- R5: The decided bit is 1 when at least two of bits 2..0 of the updated history are 1, and 0 otherwise.
- R6: Each decided bit enters a recovered-bit history, which starts at zero. The decoded output is 1 when the two newest recovered bits are equal and 0 when they differ.
- R7: `bit_valid` is high for exactly one cycle: the cycle after the sample that caused a decision. `bit_data` carries the decoded bit in that cycle and keeps it until the next decision.
- R8: While `rst` is high, the phase, both histories, `bit_valid` and `bit_data` are cleared to 0.
- R9: With a transition-free sample stream after reset, a decision occurs on exactly every eighth accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A sample bit is present this cycle |
| smp_bit | input | 1 | Hard-decision sample bit |
| bit_valid | output | 1 | One-cycle strobe for a decoded bit |
| bit_data | output | 1 | NRZI-decoded data bit |

## Verification
Constant streams of zeros and of ones, checked by hand, pin down three things: the unperturbed eight-sample cadence, the effect of a single leading transition on the phase, and the decode of the very first bit against the cleared history. Byte patterns with long and short runs are compared against a reference model written from the requirements. These patterns separate the nudge direction on either side of the midpoint, the majority vote on isolated glitches, and NRZI on alternating and repeated levels. Idle gaps show that nothing moves without a valid sample. A reset taken mid-stream shows that all state clears.

// File: rtl/bsync_pkg.sv
package bsync_pkg;
  localparam int SAMPLE_HIST_W = 8;
  localparam int PHASE_W       = 8;
  localparam int PHASE_STEP    = 8;
  localparam int PHASE_WRAP    = 64;
  localparam int PHASE_NUDGE   = 1;
  localparam int PHASE_MID     = 32;

  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/bsync_hist.sv
module bsync_hist #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] hist_q,
  output logic [W-1:0] hist_nx,
  output logic         trans
);
  always_comb begin
    hist_nx = {hist_q[W-2:0], din};
    trans   = hist_nx[1] ^ hist_nx[0];
  end

  always_ff @(posedge clk) begin
    if (rst)     hist_q <= '0;
    else if (en) hist_q <= hist_nx;
  end
endmodule

// File: rtl/bsync_phase.sv
module bsync_phase #(
  parameter int PH_W  = 8,
  parameter int STEP  = 8,
  parameter int WRAP  = 64,
  parameter int NUDGE = 1,
  parameter int MID   = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   trans,
  output logic signed [PH_W-1:0] phase_q,
  output logic                   tick
);
  localparam logic signed [PH_W-1:0] STEP_S  = PH_W'(STEP);
  localparam logic signed [PH_W-1:0] WRAP_S  = PH_W'(WRAP);
  localparam logic signed [PH_W-1:0] NUDGE_S = PH_W'(NUDGE);
  localparam logic signed [PH_W-1:0] MID_S   = PH_W'(MID);

  logic signed [PH_W-1:0] adj, adv, nxt;

  always_comb begin
    adj = phase_q;
    if (trans) begin
      if (phase_q < MID_S) adj = phase_q + NUDGE_S;
      else                 adj = phase_q - NUDGE_S;
    end
    adv  = adj + STEP_S;
    tick = (adv >= WRAP_S);
    nxt  = tick ? (adv - WRAP_S) : adv;
  end

  always_ff @(posedge clk) begin
    if (rst)     phase_q <= '0;
    else if (en) phase_q <= nxt;
  end
endmodule

// File: rtl/bsync_decide.sv
module bsync_decide #(
  parameter int REC_W = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic [2:0] recent,
  output logic       bit_valid,
  output logic       bit_data
);
  import bsync_pkg::*;

  logic [REC_W-1:0] rec_q, rec_nx;
  logic             nrzi;

  always_comb begin
    rec_nx = {rec_q[REC_W-2:0], vote3(recent)};
    nrzi   = ~(rec_nx[1] ^ rec_nx[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_q     <= '0;
      bit_valid <= 1'b0;
      bit_data  <= 1'b0;
    end else begin
      bit_valid <= en & tick;
      if (en && tick) begin
        rec_q    <= rec_nx;
        bit_data <= nrzi;
      end
    end
  end
endmodule

// File: rtl/bit_sync_nrzi.sv
module bit_sync_nrzi #(
  parameter int HIST_W = bsync_pkg::SAMPLE_HIST_W,
  parameter int PH_W   = bsync_pkg::PHASE_W,
  parameter int STEP   = bsync_pkg::PHASE_STEP,
  parameter int WRAP   = bsync_pkg::PHASE_WRAP,
  parameter int NUDGE  = bsync_pkg::PHASE_NUDGE,
  parameter int MID    = bsync_pkg::PHASE_MID
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_valid,
  input  logic smp_bit,
  output logic bit_valid,
  output logic bit_data
);
  logic [HIST_W-1:0]      hist_q, hist_nx;
  logic                   trans, tick;
  logic signed [PH_W-1:0] phase_q;

  bsync_hist #(.W(HIST_W)) u_hist (
    .clk(clk), .rst(rst), .en(smp_valid), .din(smp_bit),
    .hist_q(hist_q), .hist_nx(hist_nx), .trans(trans)
  );

  bsync_phase #(.PH_W(PH_W), .STEP(STEP), .WRAP(WRAP), .NUDGE(NUDGE), .MID(MID)) u_phase (
    .clk(clk), .rst(rst), .en(smp_valid), .trans(trans),
    .phase_q(phase_q), .tick(tick)
  );

  bsync_decide #(.REC_W(2)) u_decide (
    .clk(clk), .rst(rst), .en(smp_valid), .tick(tick),
    .recent(hist_nx[2:0]), .bit_valid(bit_valid), .bit_data(bit_data)
  );
endmodule

// File: rtl/bit_sync_nrzi_chk.sv
module bit_sync_nrzi_chk #(
  parameter int HIST_W = 8,
  parameter int PH_W   = 8,
  parameter int WRAP   = 64
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   smp_valid,
  input logic                   smp_bit,
  input logic                   bit_valid,
  input logic                   bit_data,
  input logic [HIST_W-1:0]      hist,
  input logic signed [PH_W-1:0] phase
);
  localparam logic signed [PH_W-1:0] WRAP_S = PH_W'(WRAP);

  a_r1_shift_in: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> hist[0] == $past(smp_bit));

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(hist) && $stable(phase) && $stable(bit_data));

  a_r4_phase_range: assert property (@(posedge clk) disable iff (rst)
    (phase >= 0) && (phase < WRAP_S));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);

  a_r7_needs_sample: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !bit_valid);

  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (phase == 0) && (hist == '0) && !bit_valid && !bit_data);
endmodule

bind bit_sync_nrzi bit_sync_nrzi_chk #(.HIST_W(HIST_W), .PH_W(PH_W), .WRAP(WRAP)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_bit(smp_bit),
  .bit_valid(bit_valid), .bit_data(bit_data), .hist(hist_q), .phase(phase_q)
);

// File: tb/bit_sync_nrzi_tb.sv
module bit_sync_nrzi_tb;
  logic clk = 1'b0, rst = 1'b1, smp_valid = 1'b0, smp_bit = 1'b0;
  logic bit_valid, bit_data;
  int   n_chk = 0, n_err = 0;

  // Reference state, derived from the requirements
  logic [7:0] m_hist = '0;
  logic [1:0] m_rec  = '0;
  int         m_ph   = 0;
  logic       e_v, e_d;

  localparam int NPAT = 12;
  localparam logic [7:0] PAT [NPAT] = '{8'h00, 8'hFF, 8'h0F, 8'hF0, 8'h33, 8'hCC,
                                        8'h55, 8'h3C, 8'hE7, 8'h18, 8'hF8, 8'h07};

  always #4 clk = ~clk;

  bit_sync_nrzi u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_bit(smp_bit),
    .bit_valid(bit_valid), .bit_data(bit_data)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_hist = '0; m_rec = '0; m_ph = 0;
  endtask

  task automatic model_step(input logic b);
    m_hist = {m_hist[6:0], b};
    if (m_hist[1] != m_hist[0]) m_ph = (m_ph < 32) ? m_ph + 1 : m_ph - 1;  // R2
    m_ph = m_ph + 8;                                                        // R3
    e_v = 1'b0;
    if (m_ph >= 64) begin                                                   // R4
      m_ph  = m_ph - 64;
      e_v   = 1'b1;
      m_rec = {m_rec[0], ((m_hist[0] + m_hist[1] + m_hist[2]) >= 2)};       // R5
      e_d   = (m_rec[1] == m_rec[0]);                                       // R6
    end
  endtask

  // Drive one sample, sample the outputs after the edge, return them
  task automatic drive(input logic b, output logic v, output logic d);
    @(negedge clk);
    smp_valid = 1'b1; smp_bit = b;
    @(posedge clk); #1;
    smp_valid = 1'b0;
    v = bit_valid; d = bit_data;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    logic v, d;
    int   strobes;
    do_reset();
    check(bit_valid == 0 && bit_data == 0, "R8 reset outputs", {bit_valid, bit_data}, 0);

    // R9/R6: all zeros, strobe on samples 8 and 16 only, decoded 1
    strobes = 0;
    for (int i = 1; i <= 16; i++) begin
      drive(1'b0, v, d);
      if (i % 8 == 0) begin
        check(v == 1, "R9 strobe every 8th sample", v, 1);
        check(d == 1, "R6 repeated zero decodes to 1", d, 1);
      end else check(v == 0, "R9 no strobe mid-bit", v, 0);
    end

    // R2/R6: all ones after reset: one leading transition, first decode 0 then 1
    do_reset();
    for (int i = 1; i <= 16; i++) begin
      drive(1'b1, v, d);
      if (i == 8)  check(v == 1 && d == 0, "R6 first one after cleared history", {v, d}, 2);
      else if (i == 16) check(v == 1 && d == 1, "R6 repeated one decodes to 1", {v, d}, 3);
      else check(v == 0, "R2 nudged phase keeps cadence", v, 0);
    end

    // R1/R7: idle gap, no strobe and bit_data held
    d = bit_data;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      check(bit_valid == 0 && bit_data == d, "R1 idle holds state", {bit_valid, bit_data}, {1'b0, d});
    end
    // After the gap the cadence resumes where it stopped: 8 more samples to the next strobe
    for (int i = 1; i <= 8; i++) begin
      drive(1'b1, v, d);
      check(v == (i == 8), "R1 cadence resumes after idle", v, (i == 8));
    end

    // Table walk against the reference model (R2..R7)
    do_reset();
    for (int rep = 0; rep < 3; rep++)
      for (int p = 0; p < NPAT; p++)
        for (int k = 0; k < 8; k++) begin
          logic b;
          b = PAT[p][k];
          drive(b, v, d);
          model_step(b);
          check(v == e_v, "R7 strobe timing", v, e_v);
          if (e_v) check(d == e_d, "R5 vote and R6 decode", d, e_d);
        end

    // R8: reset mid-stream clears everything; decode restarts from cleared history
    for (int i = 0; i < 3; i++) drive(1'b1, v, d);
    do_reset();
    check(bit_valid == 0 && bit_data == 0, "R8 mid-stream reset", {bit_valid, bit_data}, 0);
    strobes = 0;
    for (int i = 1; i <= 8; i++) begin
      drive(1'b0, v, d);
      if (v) strobes++;
      if (i == 8) check(v == 1 && d == 1, "R8 phase cleared, R4 wrap at 64", {v, d}, 3);
    end
    check(strobes == 1, "R4 one decision per wrap", strobes, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule